// File: doc/BRIEF.md
# Left-Justified Audio Serial Transmitter

This block turns parallel PCM sample pairs into a single serial data line for an audio codec in left-justified framing. The bit clock and the left/right word clock come from elsewhere; the block brings both into its own system clock domain through two-flop synchronisers and acts on their edges. Every channel slot starts at a word-clock transition. The most significant bit of the slot's sample is driven at once, so it is stable by the next bit-clock rising edge. Each later bit-clock falling edge moves the line to the next lower bit.

A slot is 19 bit clocks: 16 data bits, then 3 dead bit periods during which the line is held low. When the word clock rises, which starts the left slot, the block asks the upstream buffer for the next pair with a one-cycle request. It captures whatever pair is on offer in that same cycle. The right word of that pair is kept for the right slot that follows. If nothing valid is offered, the whole frame is sent as silence.

Top module: `lj_audio_tx`

## Requirements
- R1: While reset is held, `sdata` and `sample_req` are 0.
- R2: Within a slot, `sdata` changes only as a result of a detected bit-clock falling edge or a word-clock edge. Each bit-clock falling edge advances to the next lower bit, so the sample goes out MSB first.
- R3: A word-clock transition restarts the slot and puts bit 15 on `sdata`. This takes priority over a bit-clock falling edge detected in the same cycle, so that bit is not skipped.
- R4: Once all 16 bits of a slot have been shifted out, `sdata` is 0 for the rest of the slot: the 3 dead bit periods and any further falling edges before the next word-clock edge.
- R5: Word clock high carries the left sample and word clock low carries the right sample.
- R6: The pair is captured in the cycle the word-clock rise is acted on, if `pair_valid` is 1 then. Changes to `left_pcm`, `right_pcm` or `pair_valid` after that have no effect on the current frame.
- R7: If `pair_valid` is 0 when the word-clock rise is acted on, `sdata` stays 0 through both slots of that frame.
- R8: `sample_req` is a single-cycle pulse, raised once per word-clock rise. Outputs react on the third rising system-clock edge after an input clock line changes: two for the synchroniser and one for the output register.
- R9: A word-clock fall never raises `sample_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Bit clock from the clock generator, asynchronous |
| lrclk_in | input | 1 | Word clock, high = left slot, asynchronous |
| pair_valid | input | 1 | A sample pair is offered on left_pcm/right_pcm |
| left_pcm | input | 16 | Left channel sample, two's complement |
| right_pcm | input | 16 | Right channel sample, two's complement |
| sample_req | output | 1 | One-cycle request for the next pair, at left slot start |
| sdata | output | 1 | Serial data to the codec |

## Verification
The main collision is a word-clock transition and a bit-clock falling edge reaching the edge detectors in the same system cycle. This is the normal case, because the word clock is driven on a bit-clock fall. The block must restart the slot with the MSB rather than shift. The bench produces this on every slot boundary and also runs frames where the word clock moves in the middle of the bit-clock high phase. In both cases the per-cycle reference model expects bit 15 after the restart. A second overlap is the request and the capture in one cycle. The upstream model answers each request by presenting new data straight away, and the model expects the frame already captured to go out unchanged.

// File: rtl/lj_pkg.sv
package lj_pkg;
    localparam int PCM_W      = 16;
    localparam int SYNC_DEPTH = 2;
    localparam int N_CLK_IN   = 2;
    localparam int IDX_BCLK   = 0;
    localparam int IDX_LRCLK  = 1;
endpackage

// File: rtl/lj_sync_edge.sv
module lj_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-2:0], din};
        sync_d.last  = sync_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign level = sync_q.chain[STAGES-1];
    assign rise  = level & ~sync_q.last;
    assign fall  = ~level & sync_q.last;
endmodule

// File: rtl/lj_slot_shift.sv
module lj_slot_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lr_rise,
    input  logic         lr_fall,
    input  logic         bit_fall,
    input  logic         pair_valid,
    input  logic [W-1:0] left_pcm,
    input  logic [W-1:0] right_pcm,
    output logic         sdata,
    output logic         sample_req
);
    typedef struct packed {
        logic [W-1:0] shreg;
        logic [W-1:0] right;
        logic         valid;
        logic         req;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d     = sh_q;
        sh_d.req = 1'b0;
        if (lr_rise) begin
            sh_d.req   = 1'b1;
            sh_d.valid = pair_valid;
            if (pair_valid) sh_d.right = right_pcm;
            sh_d.shreg = pair_valid ? left_pcm : '0;
        end else if (lr_fall) begin
            sh_d.shreg = sh_q.valid ? sh_q.right : '0;
        end else if (bit_fall) begin
            sh_d.shreg = {sh_q.shreg[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sdata      = sh_q.shreg[W-1];
    assign sample_req = sh_q.req;

    // R7
    no_pair_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_rise && !pair_valid) |=> !sdata);
endmodule

// File: rtl/lj_audio_tx.sv
module lj_audio_tx #(
    parameter int W      = lj_pkg::PCM_W,
    parameter int STAGES = lj_pkg::SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bclk_in,
    input  logic         lrclk_in,
    input  logic         pair_valid,
    input  logic [W-1:0] left_pcm,
    input  logic [W-1:0] right_pcm,
    output logic         sample_req,
    output logic         sdata
);
    localparam int NIN = lj_pkg::N_CLK_IN;

    logic [NIN-1:0] raw_in;
    logic [NIN-1:0] lvl;
    logic [NIN-1:0] rise;
    logic [NIN-1:0] fall;

    assign raw_in[lj_pkg::IDX_BCLK]  = bclk_in;
    assign raw_in[lj_pkg::IDX_LRCLK] = lrclk_in;

    for (genvar g = 0; g < NIN; g++) begin : g_sync
        lj_sync_edge #(.STAGES(STAGES)) sync_i (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_in[g]),
            .level (lvl[g]),
            .rise  (rise[g]),
            .fall  (fall[g])
        );
    end

    logic lr_rise, lr_fall, bit_fall, lr_level_unused;
    assign lr_rise  = rise[lj_pkg::IDX_LRCLK];
    assign lr_fall  = fall[lj_pkg::IDX_LRCLK];
    assign bit_fall = fall[lj_pkg::IDX_BCLK];
    assign lr_level_unused = ^{lvl, rise[lj_pkg::IDX_BCLK]};

    lj_slot_shift #(.W(W)) shift_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lr_rise    (lr_rise),
        .lr_fall    (lr_fall),
        .bit_fall   (bit_fall),
        .pair_valid (pair_valid),
        .left_pcm   (left_pcm),
        .right_pcm  (right_pcm),
        .sdata      (sdata),
        .sample_req (sample_req)
    );

    // R2
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lr_rise && !lr_fall && !bit_fall) |=> $stable(sdata));

    // R3
    msb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_rise && pair_valid) |=> (sdata == $past(left_pcm[W-1])));

    // R8
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req |=> !sample_req);

    // R9
    req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lr_fall |=> !sample_req);
endmodule

// File: tb/lj_audio_tx_tb.sv
module lj_audio_tx_tb_top;
    localparam int HB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_in = 1'b0;
    logic        lrclk_in = 1'b0;
    logic        pair_valid = 1'b0;
    logic [15:0] left_pcm = '0;
    logic [15:0] right_pcm = '0;
    logic        sample_req;
    logic        sdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit feed_on = 0;
    int pidx = 0;

    always #2.5 clk = ~clk;

    lj_audio_tx dut_i (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
        .pair_valid(pair_valid), .left_pcm(left_pcm), .right_pcm(right_pcm),
        .sample_req(sample_req), .sdata(sdata)
    );

    function automatic logic [31:0] pair_at(input int i);
        case (i % 5)
            0: return {16'hA5C3, 16'h5A3C};
            1: return {16'hFFFF, 16'h0000};
            2: return {16'h8001, 16'h7FFE};
            3: return {16'h0000, 16'hFFFF};
            default: return {16'h1234, 16'hFEDC};
        endcase
    endfunction

    // upstream buffer: answers each request with the next pair
    always @(negedge clk) begin
        if (rst_n && sample_req) begin
            pidx <= pidx + 1;
            {left_pcm, right_pcm} <= pair_at(pidx + 1);
        end
        pair_valid <= feed_on;
    end

    // reference model
    bit   qb[$];
    bit   ql[$];
    logic [15:0] m_left, m_right, m_word;
    bit   m_valid;
    int   m_idx;
    bit   m_req;
    bit   m_sdata;

    always @(posedge clk) begin
        if (!rst_n) begin
            qb = '{0, 0, 0};
            ql = '{0, 0, 0};
            m_left = '0; m_right = '0; m_word = '0;
            m_valid = 0; m_idx = 16; m_req = 0; m_sdata = 0;
        end else begin
            qb.push_back(bclk_in);
            ql.push_back(lrclk_in);
            if (qb.size() > 4) begin
                void'(qb.pop_front());
                void'(ql.pop_front());
            end
            m_req = 0;
            if (ql[1] && !ql[0]) begin
                m_req = 1;
                m_valid = pair_valid;
                if (pair_valid) begin
                    m_left = left_pcm;
                    m_right = right_pcm;
                end
                m_word = m_left;
                m_idx = 0;
            end else if (!ql[1] && ql[0]) begin
                m_word = m_right;
                m_idx = 0;
            end else if (!qb[1] && qb[0]) begin
                m_idx++;
            end
            m_sdata = (m_valid && m_idx < 16) ? m_word[15 - m_idx] : 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            total++;
            if (sdata !== m_sdata) begin
                bad++;
                if (!m_valid)
                    $display("FAIL R7 sdata act=%b exp=%b t=%0t", sdata, m_sdata, $time);
                else if (m_idx >= 16)
                    $display("FAIL R4 sdata act=%b exp=%b t=%0t", sdata, m_sdata, $time);
                else if (m_idx == 0)
                    $display("FAIL R3 sdata act=%b exp=%b t=%0t", sdata, m_sdata, $time);
                else
                    $display("FAIL R2/R5/R6 sdata bit %0d act=%b exp=%b t=%0t",
                             m_idx, sdata, m_sdata, $time);
            end
            total++;
            if (sample_req !== m_req) begin
                bad++;
                if (m_req)
                    $display("FAIL R8 sample_req act=%b exp=%b t=%0t", sample_req, m_req, $time);
                else
                    $display("FAIL R9 sample_req act=%b exp=%b t=%0t", sample_req, m_req, $time);
            end
        end
    end

    // one 19-bit-clock slot; skew>0 moves the word clock into the high phase
    task automatic run_half(input logic level, input int skew);
        for (int b = 0; b < 19; b++) begin
            if (b == 0 && skew == 0) lrclk_in = level;
            bclk_in = 1'b0;
            repeat (HB) @(negedge clk);
            bclk_in = 1'b1;
            if (b == 0 && skew > 0) begin
                repeat (skew) @(negedge clk);
                lrclk_in = level;
                repeat (HB - skew) @(negedge clk);
            end else begin
                repeat (HB) @(negedge clk);
            end
        end
    endtask

    task automatic run_frame(input int skew);
        run_half(1'b1, skew);   // R5 left slot
        run_half(1'b0, skew);   // R5 right slot
    endtask

    initial begin
        {left_pcm, right_pcm} = pair_at(0);
        repeat (4) @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 3; i++) begin
            total++;
            if (sdata !== 1'b0 || sample_req !== 1'b0) begin
                bad++;
                $display("FAIL R1 reset act=%b%b exp=00", sdata, sample_req);
            end
            @(negedge clk);
        end
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        feed_on = 1;
        @(negedge clk);
        // R2 R3 R4 R6 R8: aligned frames with fresh pairs
        for (int f = 0; f < 4; f++) run_frame(0);
        // R7: no pair on offer for one frame
        feed_on = 0;
        run_frame(0);
        feed_on = 1;
        // R3: word clock moves inside the bit-clock high phase
        for (int f = 0; f < 2; f++) run_frame(2);
        run_frame(0);
        repeat (8) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule